// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block sits between a processor's instruction fetch port and a slower external memory. It holds 4 KB of code in two ways of 128 sets each, with lines of four 32-bit words. A fetch that hits returns its word on the next cycle. A fetch that misses stalls the fetch port. The cache then issues one line-aligned request, collects four strobed beats into the chosen way, and returns the requested (critical) word. Replacement within a set uses one LRU bit.

Software can pin code by fetching it with `fetch_lock` raised. A locked line is never evicted. Each way can also be taken out of cache service through `ram_mode`. A way in RAM mode is read and written directly as instruction RAM through a separate word port. A global invalidate drops every cached line but keeps the lock bits and the RAM contents.

The controller has four states. `ST_IDLE` waits for a fetch. `ST_CHECK` compares tags. `ST_FILL` collects refill beats. `ST_DONE` returns the critical word. The transitions are:

- IDLE→CHECK when a fetch is accepted.
- CHECK→CHECK on a hit with a new fetch pending.
- CHECK→IDLE on a hit with no fetch pending.
- CHECK→FILL on a miss.
- FILL→DONE on the fourth beat.
- DONE→CHECK with a new fetch pending.
- DONE→IDLE with no fetch pending.

Top module: `icache_lockable`

## Requirements
- R1: After reset all valid bits, lock bits and LRU bits are zero (way 0 is the first victim). `fetch_ready` is 1, `fetch_valid` is 0, `mem_req` is 0 and `ram_rdata` is 0.
- R2: The address splits into word select [3:2], set index [10:4] and tag [31:11]. A hit returns the addressed word with `fetch_valid` high in the cycle after the fetch is accepted, and raises no memory request.
- R3: A miss raises `mem_req` for exactly one cycle, in the cycle after acceptance, with `mem_addr` equal to the fetch address with bits [3:0] cleared. `fetch_ready` stays low until the miss is served.
- R4: A refill takes four beats, and a beat counts only when `mem_beat_valid` is high. Beat n carries word n of the line. `fetch_valid` rises with the critical word in the cycle after the fourth beat.
- R5: When both ways of a set can be allocated, the set's LRU bit names the victim. A hit on way w, or a fill into way w, makes the other way the next victim.
- R6: A fetch with `fetch_lock` high sets the lock bit of its line on a hit or on an allocating fill. A locked line is never replaced, and if only one way of a set is allocatable that way is the victim.
- R7: If neither way of a set is allocatable (each is locked or in RAM mode), a miss is served from memory without allocating, so a repeat of that fetch misses again.
- R8: A one-cycle `cache_inval` clears every valid bit and leaves lock bits unchanged. `unlock_all` clears every lock bit.
- R9: A way whose `ram_mode` bit is 1 never produces a hit and is never filled.
- R10: The RAM port reaches word `ram_addr` = {set index, word select} of way `ram_way` when that way is in RAM mode. Read data appears on `ram_rdata` one cycle after the request, and the storage is the same one the cache fills.
- R11: A RAM access to a way not in RAM mode has no effect: a write changes nothing and a read returns zero.
- R12: A RAM write into a way in RAM mode clears the valid bit of the line it touches, so that line misses after the way returns to cache use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, taken when `fetch_ready` is high |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_lock | input | 1 | Lock the fetched line in the cache |
| fetch_ready | output | 1 | A new fetch can be accepted this cycle |
| fetch_valid | output | 1 | `fetch_data` holds the word of the last accepted fetch |
| fetch_data | output | 32 | Instruction word |
| mem_req | output | 1 | One-cycle line refill request |
| mem_addr | output | 32 | Line-aligned refill address |
| mem_beat_valid | input | 1 | Refill beat strobe |
| mem_beat_data | input | 32 | Refill beat word |
| cache_inval | input | 1 | Clear all valid bits |
| unlock_all | input | 1 | Clear all lock bits |
| ram_mode | input | 2 | Per-way RAM-mode select |
| ram_en | input | 1 | RAM port access strobe |
| ram_we | input | 1 | RAM port write (1) or read (0) |
| ram_way | input | 1 | Way addressed by the RAM port |
| ram_addr | input | 9 | {set index, word select} |
| ram_wdata | input | 32 | RAM port write word |
| ram_rdata | output | 32 | RAM port read word, one cycle after the request |

## Verification
Every result in this design arrives at a fixed offset from its stimulus.

| Result | When it is due |
|---|---|
| Hit data | the cycle after acceptance |
| Memory request of a miss | the cycle after acceptance |
| Critical word | the cycle after the fourth strobed beat |
| RAM read data | one cycle after `ram_en` |

The bench uses a behavioural model of tags, valid, lock and LRU state to predict hit or miss and the victim way. Its memory responder has a fixed schedule: it sends one bubble between the second and third beats. This puts the critical word six cycles after the check cycle. On every cycle of a fetch, the bench samples at the falling edge and compares `fetch_valid`, `fetch_ready` and `mem_req` with the value due in that cycle.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FILL,
        ST_DONE
    } ic_state_e;

    localparam int unsigned IC_WAYS = 2;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
    parameter int unsigned SETS  = 128,
    parameter int unsigned TAG_W = 21,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [1:0]       ram_mode,
    output logic [1:0]       hit,
    output logic             victim,
    output logic             alloc_ok,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             lock_en,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             inval,
    input  logic             unlock_all,
    input  logic             kill_en,
    input  logic             kill_way,
    input  logic [IDX_W-1:0] kill_idx
);
    logic [TAG_W-1:0]          tag_q [icache_pkg::IC_WAYS][SETS];
    logic [1:0][SETS-1:0]      valid_q;
    logic [1:0][SETS-1:0]      lock_q;
    logic [SETS-1:0]           lru_q;
    logic [1:0]                avail;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign hit[w]   = valid_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag) && !ram_mode[w];
        assign avail[w] = !lock_q[w][lk_idx] && !ram_mode[w];
    end

    assign alloc_ok = |avail;
    assign victim   = (&avail) ? lru_q[lk_idx] : avail[1];

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_way][lk_idx] <= lk_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            lock_q  <= '0;
            lru_q   <= '0;
        end else begin
            if (fill_en)  valid_q[fill_way][lk_idx]   <= 1'b1;
            if (kill_en)  valid_q[kill_way][kill_idx] <= 1'b0;
            if (inval)    valid_q <= '0;
            if (lock_en)  lock_q[touch_way][lk_idx] <= 1'b1;
            if (unlock_all) lock_q <= '0;
            if (touch_en) lru_q[lk_idx] <= ~touch_way;
        end
    end

    assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_locked_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !lock_q[fill_way][lk_idx]);
    assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (valid_q == '0));
    assert_inval_keeps_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inval && !unlock_all && !lock_en) |=> $stable(lock_q));
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 128,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned DEPTH = SETS * WORDS,
    localparam int unsigned RA_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_way0,
    output logic [DATA_W-1:0] rd_way1,
    input  logic              fill_we,
    input  logic              fill_way,
    input  logic [RA_W-1:0]   fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [1:0]        ram_mode,
    input  logic              ram_en,
    input  logic              ram_we,
    input  logic              ram_way,
    input  logic [RA_W-1:0]   ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] ram_rdata
);
    logic [DATA_W-1:0] mem_q [icache_pkg::IC_WAYS][DEPTH];
    logic              ram_ok;

    assign ram_ok  = ram_en && ram_mode[ram_way];
    assign rd_way0 = mem_q[0][rd_addr];
    assign rd_way1 = mem_q[1][rd_addr];

    always_ff @(posedge clk) begin
        if (fill_we) mem_q[fill_way][fill_addr] <= fill_data;
        if (ram_ok && ram_we) mem_q[ram_way][ram_addr] <= ram_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ram_rdata <= '0;
        else if (ram_en && !ram_we) ram_rdata <= ram_ok ? mem_q[ram_way][ram_addr] : '0;
    end

    assert_fill_not_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !ram_mode[fill_way]);
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned OFF_W  = BYTE_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_lock,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data,
    output logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        hit,
    input  logic              victim,
    input  logic              alloc_ok,
    input  logic [DATA_W-1:0] way0_data,
    input  logic [DATA_W-1:0] way1_data,
    output logic              touch_en,
    output logic              touch_way,
    output logic              lock_en,
    output logic              fill_en,
    output logic              fill_we,
    output logic              fill_way,
    output logic [WSEL_W-1:0] fill_word
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    ic_state_e         state_q, state_d;
    logic              req_lock_q, alloc_q, vway_q;
    logic [WSEL_W-1:0] beat_q, req_word;
    logic [DATA_W-1:0] crit_q;
    logic              any_hit, accept;

    assign any_hit   = |hit;
    assign accept    = fetch_req && fetch_ready;
    assign req_word  = req_addr[OFF_W-1:BYTE_W];
    assign mem_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign fill_word = beat_q;
    assign fill_way  = vway_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr   <= '0;
            req_lock_q <= 1'b0;
            alloc_q    <= 1'b0;
            vway_q     <= 1'b0;
            beat_q     <= '0;
            crit_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_addr   <= fetch_addr;
                req_lock_q <= fetch_lock;
            end
            if (state_q == ST_CHECK && !any_hit) begin
                beat_q  <= '0;
                alloc_q <= alloc_ok;
                vway_q  <= victim;
            end
            if (state_q == ST_FILL && mem_beat_valid) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == req_word) crit_q <= mem_beat_data;
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        fetch_valid = 1'b0;
        fetch_data  = '0;
        mem_req     = 1'b0;
        touch_en    = 1'b0;
        touch_way   = 1'b0;
        lock_en     = 1'b0;
        fill_en     = 1'b0;
        fill_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fetch_ready = 1'b1;
                if (fetch_req) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (any_hit) begin
                    fetch_valid = 1'b1;
                    fetch_data  = hit[1] ? way1_data : way0_data;
                    fetch_ready = 1'b1;
                    touch_en    = 1'b1;
                    touch_way   = hit[1];
                    lock_en     = req_lock_q;
                    state_d     = fetch_req ? ST_CHECK : ST_IDLE;
                end else begin
                    mem_req = 1'b1;
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_beat_valid) begin
                    fill_we = alloc_q;
                    if (beat_q == LAST_BEAT) begin
                        fill_en   = alloc_q;
                        touch_en  = alloc_q;
                        touch_way = vway_q;
                        lock_en   = alloc_q && req_lock_q;
                        state_d   = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                fetch_valid = 1'b1;
                fetch_data  = crit_q;
                fetch_ready = 1'b1;
                state_d     = fetch_req ? ST_CHECK : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_valid_after_last_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_beat_valid && beat_q == LAST_BEAT) |=> fetch_valid);
endmodule

// File: rtl/icache_lockable.sv
module icache_lockable #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 128,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned OFF_W  = BYTE_W + WSEL_W,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned RA_W   = IDX_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_lock,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data,
    input  logic              cache_inval,
    input  logic              unlock_all,
    input  logic [1:0]        ram_mode,
    input  logic              ram_en,
    input  logic              ram_we,
    input  logic              ram_way,
    input  logic [RA_W-1:0]   ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] ram_rdata
);
    logic [ADDR_W-1:0] req_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [1:0]        hit;
    logic              victim, alloc_ok, touch_en, touch_way, lock_en;
    logic              fill_en, fill_we, fill_way, kill_en;
    logic [WSEL_W-1:0] fill_word;
    logic [DATA_W-1:0] way0_data, way1_data;

    assign lk_idx  = req_addr[OFF_W +: IDX_W];
    assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign kill_en = ram_en && ram_we && ram_mode[ram_way];

    ic_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ctrl (
        .clk, .rst_n, .fetch_req, .fetch_addr, .fetch_lock, .fetch_ready,
        .fetch_valid, .fetch_data, .mem_req, .mem_addr, .mem_beat_valid,
        .mem_beat_data, .req_addr, .hit, .victim, .alloc_ok, .way0_data,
        .way1_data, .touch_en, .touch_way, .lock_en, .fill_en, .fill_we,
        .fill_way, .fill_word
    );

    ic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk, .rst_n, .lk_idx, .lk_tag, .ram_mode, .hit, .victim, .alloc_ok,
        .touch_en, .touch_way, .lock_en, .fill_en, .fill_way,
        .inval(cache_inval), .unlock_all, .kill_en, .kill_way(ram_way),
        .kill_idx(ram_addr[RA_W-1:WSEL_W])
    );

    ic_data_store #(.DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) u_data (
        .clk, .rst_n,
        .rd_addr({lk_idx, req_addr[OFF_W-1:BYTE_W]}),
        .rd_way0(way0_data), .rd_way1(way1_data),
        .fill_we, .fill_way, .fill_addr({lk_idx, fill_word}),
        .fill_data(mem_beat_data), .ram_mode, .ram_en, .ram_we, .ram_way,
        .ram_addr, .ram_wdata, .ram_rdata
    );
endmodule

// File: tb/tb_icache_lockable.sv
module tb_icache_lockable;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 0, fetch_lock = 0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, fetch_valid, mem_req;
    logic [31:0] fetch_data, mem_addr, ram_rdata;
    logic        mem_beat_valid = 0;
    logic [31:0] mem_beat_data = '0;
    logic        cache_inval = 0, unlock_all = 0;
    logic [1:0]  ram_mode = 2'b00;
    logic        ram_en = 0, ram_we = 0, ram_way = 0;
    logic [8:0]  ram_addr = '0;
    logic [31:0] ram_wdata = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model state
    bit          m_valid [2][128];
    bit [20:0]   m_tag   [2][128];
    bit          m_lock  [2][128];
    bit          m_lru   [128];

    localparam int MISS_LAT = 6; // check cycle to critical word with the responder below

    always #2 clk = ~clk;

    icache_lockable dut (
        .clk, .rst_n, .fetch_req, .fetch_addr, .fetch_lock, .fetch_ready,
        .fetch_valid, .fetch_data, .mem_req, .mem_addr, .mem_beat_valid,
        .mem_beat_data, .cache_inval, .unlock_all, .ram_mode, .ram_en,
        .ram_we, .ram_way, .ram_addr, .ram_wdata, .ram_rdata
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ((a >> 2) * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] mk(input int tg, input int idx, input int wd);
        return {tg[20:0], idx[6:0], wd[1:0], 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: bubble between beats 1 and 2
    initial begin
        forever begin
            @(negedge clk);
            mem_beat_valid = 1'b0;
            if (mem_req && rst_n) begin
                logic [31:0] line;
                line = mem_addr;
                for (int b = 0; b < 4; b++) begin
                    @(negedge clk);
                    if (b == 2) begin
                        mem_beat_valid = 1'b0;
                        @(negedge clk);
                    end
                    mem_beat_valid = 1'b1;
                    mem_beat_data  = mem_word(line | (b << 2));
                end
            end
        end
    end

    task automatic do_fetch(input logic [31:0] a, input bit lk, input string req);
        int idx, hw, v;
        bit [20:0] tg;
        bit av0, av1;
        idx = int'(a[10:4]);
        tg  = a[31:11];
        hw  = -1;
        for (int w = 0; w < 2; w++)
            if (m_valid[w][idx] && m_tag[w][idx] == tg && !ram_mode[w]) hw = w;
        fetch_req = 1; fetch_addr = a; fetch_lock = lk;
        @(negedge clk);
        fetch_req = 0; fetch_lock = 0;
        if (hw >= 0) begin
            chk(fetch_valid && !mem_req, req, "hit due next cycle", {fetch_valid, mem_req}, 2'b10);
            chk(fetch_data == mem_word(a), req, "hit data", fetch_data, mem_word(a));
            m_lru[idx] = (hw == 0);
            if (lk) m_lock[hw][idx] = 1;
        end else begin
            chk(!fetch_valid && mem_req, req, "miss request (R3)", {fetch_valid, mem_req}, 2'b01);
            chk(mem_addr == {a[31:4], 4'h0}, req, "aligned line address (R3)", mem_addr, {a[31:4], 4'h0});
            for (int c = 1; c < MISS_LAT; c++) begin
                @(negedge clk);
                chk(!fetch_valid && !fetch_ready && !mem_req, req, "stall during refill (R4)",
                    {fetch_valid, fetch_ready, mem_req}, 3'b000);
            end
            @(negedge clk);
            chk(fetch_valid && fetch_data == mem_word(a), req, "critical word (R4)",
                {31'b0, fetch_valid, fetch_data}, {32'h1, mem_word(a)});
            av0 = !m_lock[0][idx] && !ram_mode[0];
            av1 = !m_lock[1][idx] && !ram_mode[1];
            v = -1;
            if (av0 && av1) v = int'(m_lru[idx]);
            else if (av1) v = 1;
            else if (av0) v = 0;
            if (v >= 0) begin
                m_valid[v][idx] = 1;
                m_tag[v][idx]   = tg;
                m_lru[idx]      = (v == 0);
                if (lk) m_lock[v][idx] = 1;
            end
        end
    endtask

    task automatic ram_wr(input bit way, input int idx, input int wd, input logic [31:0] d);
        ram_en = 1; ram_we = 1; ram_way = way; ram_addr = {idx[6:0], wd[1:0]}; ram_wdata = d;
        @(negedge clk);
        ram_en = 0; ram_we = 0;
        if (ram_mode[way]) m_valid[way][idx] = 0;
    endtask

    task automatic ram_rd(input bit way, input int idx, input int wd,
                          input logic [31:0] exp, input string req);
        ram_en = 1; ram_we = 0; ram_way = way; ram_addr = {idx[6:0], wd[1:0]};
        @(negedge clk);
        ram_en = 0;
        chk(ram_rdata == exp, req, "RAM port read", ram_rdata, exp);
    endtask

    task automatic pulse_inval();
        cache_inval = 1;
        @(negedge clk);
        cache_inval = 0;
        for (int w = 0; w < 2; w++) for (int s = 0; s < 128; s++) m_valid[w][s] = 0;
    endtask

    task automatic pulse_unlock();
        unlock_all = 1;
        @(negedge clk);
        unlock_all = 0;
        for (int w = 0; w < 2; w++) for (int s = 0; s < 128; s++) m_lock[w][s] = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 128; s++) begin
                m_valid[w][s] = 0; m_lock[w][s] = 0; m_tag[w][s] = '0; m_lru[s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fetch_ready && !fetch_valid && !mem_req && ram_rdata == 0, "R1", "reset outputs",
            {fetch_ready, fetch_valid, mem_req, ram_rdata}, {3'b100, 32'h0});

        // R2 R3 R4 R5: fills, hits and LRU eviction in set 5
        do_fetch(mk(1, 5, 2), 0, "R3");
        do_fetch(mk(1, 5, 0), 0, "R2");
        do_fetch(mk(2, 5, 3), 0, "R5");
        do_fetch(mk(1, 5, 1), 0, "R2");
        do_fetch(mk(3, 5, 0), 0, "R5");
        do_fetch(mk(2, 5, 0), 0, "R5");
        do_fetch(mk(3, 5, 1), 0, "R5");

        // R10: cache-filled storage readable through the RAM port
        ram_mode = 2'b01;
        ram_rd(0, 5, 0, mem_word(mk(2, 5, 0)), "R10");
        // R9: way 0 in RAM mode never hits or fills
        do_fetch(mk(2, 5, 0), 0, "R9");
        do_fetch(mk(5, 5, 0), 0, "R9");
        ram_mode = 2'b00;
        @(negedge clk);

        // R6 R7: locking in set 9
        do_fetch(mk(7, 9, 0), 1, "R6");
        do_fetch(mk(8, 9, 0), 0, "R6");
        do_fetch(mk(9, 9, 0), 0, "R6");
        do_fetch(mk(7, 9, 1), 0, "R6");
        do_fetch(mk(10, 9, 0), 1, "R6");
        do_fetch(mk(11, 9, 0), 0, "R7");
        do_fetch(mk(11, 9, 0), 0, "R7");
        do_fetch(mk(10, 9, 2), 0, "R7");

        // R8: invalidate keeps locks; unlock frees the set
        pulse_inval();
        do_fetch(mk(2, 5, 0), 0, "R8");
        do_fetch(mk(7, 9, 0), 0, "R8");
        do_fetch(mk(7, 9, 0), 0, "R8");
        pulse_unlock();
        do_fetch(mk(7, 9, 0), 0, "R8");
        do_fetch(mk(7, 9, 3), 0, "R8");

        // R10 R11: RAM port behaviour
        ram_mode = 2'b10;
        ram_wr(1, 20, 1, 32'hDEAD_BEEF);
        ram_rd(1, 20, 1, 32'hDEAD_BEEF, "R10");
        do_fetch(mk(12, 30, 0), 0, "R11");
        ram_wr(0, 30, 0, 32'h0BAD_0BAD);
        ram_rd(0, 30, 0, 32'h0, "R11");
        do_fetch(mk(12, 30, 0), 0, "R11");

        // R12: RAM write drops a cached line
        ram_mode = 2'b00;
        do_fetch(mk(13, 40, 0), 0, "R12");
        do_fetch(mk(14, 40, 0), 0, "R12");
        ram_mode = 2'b10;
        ram_wr(1, 40, 3, 32'h1234_5678);
        ram_mode = 2'b00;
        @(negedge clk);
        do_fetch(mk(14, 40, 0), 0, "R12");
        do_fetch(mk(13, 40, 0), 0, "R12");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule